// File: doc/BRIEF.md
# Remote Terminal Address Latch

This block holds the 5-bit address of a serial bus remote terminal together with the address's parity bit, and it reports whether that pair has valid odd parity. The address can come from five dedicated input pins and a parity pin, or it can come from the host's register write bus. A configuration bit selects the source.

A latch-control pin sets how the address is captured:
- **Low:** the pin values flow straight into the address register, one clock later.
- **Rising:** a rising edge freezes the pin values in the register.
- **Held high:** the address loads only when the host runs a three-step sequence of configuration writes. The host sets an enhanced-mode enable, then sets a load-on-write enable, then writes the load register.

The latch-control pin is asynchronous, so it passes through a two-flop synchronizer before any of these decisions use it. The parity-valid output gates the terminal's response to non-broadcast commands. The broadcast output flags the all-ones address regardless of parity.

Top module: `rt_addr_latch`

## Requirements
- R1: After reset, `term_addr` is 0, `term_par` is 0, `par_ok` is 0, `bcast` is 0, and the three configuration bits (enhanced-mode at register 3 bit 15, load-enable at register 4 bit 3, source-select at register 6 bit 5) are 0.
- R2: With source-select at 0 and the synchronized latch-control pin at 0, `{term_addr, term_par}` equals `{addr_pins, par_pin}` as sampled on the previous clock edge.
- R3: With source-select at 0, a 0-to-1 transition of the synchronized latch-control pin captures the pin values. Pin changes made afterwards, while the latch-control pin stays 1, do not alter the outputs.
- R4: With the synchronized latch-control pin at 1, a write to register address 5 loads a new address only when register 3 bit 15 and register 4 bit 3 are both 1. The outputs change on the clock edge of that write.
- R5: With source-select (register 6 bit 5) at 1, a qualifying write to register 5 loads `term_addr` from `wr_data[5:1]` and `term_par` from `wr_data[0]`. The address and parity pins have no effect, whatever the level of the latch-control pin.
- R6: With source-select at 0, a qualifying write to register 5 loads the pin values, and `wr_data` is ignored.
- R7: With the latch-control pin at 1, a write to register 5 while either enable bit is 0 leaves `term_addr` and `term_par` unchanged.
- R8: `par_ok` is 1 exactly when `term_addr` and `term_par` together contain an odd number of ones.
- R9: `bcast` is 1 exactly when `term_addr` is 31. It does not depend on `par_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_pins | input | 5 | Address pins, bit 4 is the MSB |
| par_pin | input | 1 | Address parity pin |
| latch_pin | input | 1 | Latch control, asynchronous |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address (3, 4, 5 or 6) |
| wr_data | input | 16 | Host write data |
| term_addr | output | 5 | Held terminal address |
| term_par | output | 1 | Held parity bit |
| par_ok | output | 1 | Odd parity over address and parity |
| bcast | output | 1 | Held address is the broadcast address |

## Verification
The hardest state to reach is a host-controlled load with both sources present. This requires the synchronized latch-control pin to sit high, with both enables set before the write to register 5, and the pins and data bus must carry deliberately different words so that the chosen source can be told apart. The bench raises the latch pin and waits out the synchronizer. It then drives the pins with the bitwise complement of the bus data while it sweeps all 64 bus words through register 5. It repeats the load with one enable cleared, expecting the held value to stay put.

// File: rtl/rt_addr_latch.sv
module rt_addr_latch #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic              par_pin,
  input  logic              latch_pin,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] term_addr,
  output logic              term_par,
  output logic              par_ok,
  output logic              bcast
);
  localparam int TW = ADDR_W + 1;
  localparam logic [REG_AW-1:0] REG_ENH  = REG_AW'(3);
  localparam logic [REG_AW-1:0] REG_LCTL = REG_AW'(4);
  localparam logic [REG_AW-1:0] REG_LOAD = REG_AW'(5);
  localparam logic [REG_AW-1:0] REG_SRC  = REG_AW'(6);
  localparam int ENH_BIT  = 15;
  localparam int LCTL_BIT = 3;
  localparam int SRC_BIT  = 5;

  logic [2:0]    lsync;
  logic          enh_q, lctl_q, src_q;
  logic [TW-1:0] word_q;

  wire           lat_s    = lsync[1];
  wire           lat_rise = lsync[1] & ~lsync[2];
  wire           wr_load  = wr_en && (wr_addr == REG_LOAD);
  wire           host_go  = wr_load & enh_q & lctl_q & lat_s;
  wire [TW-1:0]  pin_word = {addr_pins, par_pin};
  wire [TW-1:0]  bus_word = wr_data[TW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsync  <= '0;
      enh_q  <= 1'b0;
      lctl_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      lsync <= {lsync[1:0], latch_pin};
      if (wr_en && wr_addr == REG_ENH)  enh_q  <= wr_data[ENH_BIT];
      if (wr_en && wr_addr == REG_LCTL) lctl_q <= wr_data[LCTL_BIT];
      if (wr_en && wr_addr == REG_SRC)  src_q  <= wr_data[SRC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (src_q) begin
      if (host_go) word_q <= bus_word;
    end else if (!lat_s || lat_rise || host_go)
      word_q <= pin_word;
  end

  assign term_addr = word_q[TW-1:1];
  assign term_par  = word_q[0];
  assign par_ok    = ^word_q;
  assign bcast     = &word_q[TW-1:1];
endmodule

// File: rtl/rt_addr_latch_chk.sv
module rt_addr_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] addr_pins,
  input logic       par_pin,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [5:0] wr_data_lo,
  input logic [5:0] word,
  input logic       lat_s,
  input logic       enh,
  input logic       lctl,
  input logic       src
);
  wire load_wr = wr_en && wr_addr == 3'd5;

  assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src && !lat_s) |=> word == $past({addr_pins, par_pin}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_s && $past(lat_s) && !load_wr) |=> $stable(word));

  assert_bus_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src && load_wr && enh && lctl && lat_s) |=> word == $past(wr_data_lo));

  assert_pins_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src && !load_wr) |=> $stable(word));

  assert_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_s && $past(lat_s) && !(enh && lctl)) |=> $stable(word));
endmodule

bind rt_addr_latch rt_addr_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .par_pin(par_pin),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data_lo(wr_data[5:0]),
  .word(word_q), .lat_s(lsync[1]), .enh(enh_q), .lctl(lctl_q), .src(src_q)
);

// File: tb/test_rt_addr_latch.sv
module test_rt_addr_latch;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 0, rst_n = 0;
  logic [4:0]  addr_pins = 0;
  logic        par_pin = 0, latch_pin = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [4:0]  term_addr;
  logic        term_par, par_ok, bcast;
  int checks = 0, errors = 0;
  bit done = 0;

  rt_addr_latch i_rt_addr_latch (
    .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins), .par_pin(par_pin),
    .latch_pin(latch_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .term_addr(term_addr), .term_par(term_par), .par_ok(par_ok), .bcast(bcast)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_word(string req, logic [5:0] w);
    chk(req, {3'b0, term_addr}, {3'b0, w[5:1]});
    chk(req, {7'b0, term_par}, {7'b0, w[0]});
    chk({req, "/R8"}, {7'b0, par_ok}, {7'b0, ^w});
    chk({req, "/R9"}, {7'b0, bcast}, {7'b0, w[5:1] == 5'd31});
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 16'hxxxx;
  endtask

  task automatic set_pins(logic [5:0] w);
    {addr_pins, par_pin} = w;
  endtask

  initial begin
    logic [5:0] held;
    repeat (3) @(negedge clk);
    // R1
    chk_word("R1", 6'd0);
    rst_n = 1;
    @(negedge clk);

    // R2, R8, R9: transparent sweep over every address/parity pair
    for (int i = 0; i < 64; i++) begin
      set_pins(6'(i));
      @(negedge clk);
      chk_word("R2", 6'(i));
    end

    // R9: broadcast address with even parity
    set_pins({5'd31, 1'b1});
    @(negedge clk);
    chk("R9", {6'b0, bcast, par_ok}, 8'b10);

    // R3: rising edge capture
    set_pins({5'd10, 1'b0});
    repeat (2) @(negedge clk);
    latch_pin = 1;
    repeat (4) @(negedge clk);
    set_pins({5'd21, 1'b1});
    repeat (3) @(negedge clk);
    chk_word("R3", {5'd10, 1'b0});

    // R6/R4: host load with pin source, bus data ignored
    wr(3'd3, 16'h8000);
    wr(3'd4, 16'h0008);
    for (int i = 0; i < 64; i += 7) begin
      set_pins(6'(i));
      wr(3'd5, 16'(~i));
      chk_word("R6", 6'(i));
    end

    // R7: one enable cleared
    held = {term_addr, term_par};
    wr(3'd4, 16'h0000);
    set_pins(~held);
    wr(3'd5, 16'h003f);
    @(negedge clk);
    chk_word("R7", held);
    wr(3'd4, 16'h0008);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'h0000);
    chk_word("R7", held);
    wr(3'd3, 16'h8000);

    // R5/R4: bus source sweep, pins carry the complement
    wr(3'd6, 16'h0020);
    for (int j = 0; j < 64; j++) begin
      set_pins(~6'(j));
      wr(3'd5, 16'(j));
      chk_word("R5", 6'(j));
    end

    // R5: pins ignored even with latch pin low
    held = {term_addr, term_par};
    latch_pin = 0;
    repeat (3) @(negedge clk);
    set_pins(~held);
    repeat (3) @(negedge clk);
    chk_word("R5", held);

    // R4: bus write while latch pin is low does not load
    wr(3'd5, 16'h0015);
    @(negedge clk);
    chk_word("R4", held);

    done = 1;
  end

  initial begin
    for (int n = 0; n < WATCHDOG && !done; n++) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule